// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits behind a two-wire serial memory's bus engine and owns everything between the decoded bus events and a 512-byte storage array. It keeps the internal address counter. It gathers the bytes of a write burst in a sixteen-entry staging buffer. When the engine reports a stop, it commits the staged bytes to the array in one step and then holds a busy flag for a fixed, self-timed window. That window stands in for the nonvolatile programming time.

The bus engine drives single-cycle strobes. It can load a word address, deliver a data byte, advance the counter after a read byte, or report a stop. It reads the byte at the counter from a combinational data output. While the busy flag is high the engine is expected not to answer its address, and the block itself discards every strobe. The length of the busy window is a parameter counted in system clocks.

Top module: `wb_page_seq`

## Requirements
- R1: After synchronous reset, busy_o is low, addr_o is 0 and every array location reads 0.
- R2: An accepted load strobe sets addr_o to ld_addr_i on the next clock.
- R3: An accepted write strobe stages wr_data_i in the buffer entry chosen by addr_o[3:0]. It then increments addr_o[3:0] modulo 16 and leaves addr_o[8:4] unchanged.
- R4: A burst of more than sixteen bytes wraps inside its page, and later bytes replace earlier staged bytes at the same offset.
- R5: An accepted read-advance strobe increments all nine bits of addr_o, and address 511 rolls over to 0.
- R6: rd_data_o always shows the array byte at addr_o. After an access to n the counter holds the next address: n+1 for reads, and the page-wrapped n+1 for writes.
- R7: The array is unchanged until a stop. On an accepted stop, every staged byte is written at {addr_o[8:4], offset} and is visible on the following cycle.
- R8: A stop with at least one staged byte raises busy_o on the next clock, and busy_o stays high for exactly CYCLE_CLKS cycles.
- R9: While busy_o is high, load, write, read-advance and stop strobes have no effect on the counter, the array or the staging buffer.
- R10: A stop with no staged bytes leaves busy_o low and the counter and array unchanged.
- R11: Only offsets that received a byte since the last load or stop are written at commit. A load discards any staged bytes.
- R12: When strobes coincide, the priority is stop over load, load over write, and write over read-advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load the address counter |
| ld_addr_i | input | 9 | Word address to load |
| wr_i | input | 1 | Stage one data byte |
| wr_data_i | input | 8 | Byte to stage |
| rd_adv_i | input | 1 | Advance the counter after a read byte |
| stop_i | input | 1 | End of transfer; commits staged bytes |
| busy_o | output | 1 | Self-timed write window in progress |
| addr_o | output | 9 | Current address counter |
| rd_data_o | output | 8 | Array byte at the current address |

## Verification
The case hardest to reach from the ports is a strobe arriving inside the busy window. A correct bus engine never sends one, so the stimulus fires load, write, read-advance and stop pulses on purpose during a commit. It then proves through addr_o and a page read-back that none of them took effect. Bursts longer than sixteen bytes, partial pages and empty stops are aimed at on purpose, and randomized bursts at random addresses are mixed in. Every write is checked against a bench-side model of the counter, the staging buffer and the array.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int DATA_W  = 8;
    localparam int OFF_W   = 4;
    localparam int PAGE_W  = 5;
    localparam int ADDR_W  = PAGE_W + OFF_W;
    localparam int ENTRIES = 1 << OFF_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } waddr_t;

    typedef logic [ENTRIES-1:0][DATA_W-1:0] stage_data_t;
    typedef logic [ENTRIES-1:0]             stage_vld_t;

    // write bursts stay inside their page
    function automatic waddr_t next_wr(input waddr_t a);
        waddr_t n;
        n.page = a.page;
        n.off  = a.off + 1'b1;
        return n;
    endfunction

    // reads walk the whole array
    function automatic waddr_t next_rd(input waddr_t a);
        return waddr_t'(a + 1'b1);
    endfunction
endpackage

// File: rtl/wb_addr_ctr.sv
module wb_addr_ctr
    import wb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  waddr_t ld_val,
    input  logic   wr,
    input  logic   rd,
    output waddr_t addr
);
    always_ff @(posedge clk) begin
        if (rst)     addr <= '0;
        else if (ld) addr <= ld_val;
        else if (wr) addr <= next_wr(addr);
        else if (rd) addr <= next_rd(addr);
    end

    // R3: write step keeps page, bumps offset
    p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && !ld) |=> (addr.page == $past(addr.page)) &&
                        (addr.off == OFF_W'($past(addr.off) + 1)));

    // R5: read step advances all bits
    p_read_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && !ld && !wr) |=> (addr == ADDR_W'($past(addr) + 1)));

    // R2
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (addr == $past(ld_val)));
endmodule

// File: rtl/wb_stage.sv
module wb_stage
    import wb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                wr,
    input  logic [OFF_W-1:0]    idx,
    input  byte_t               din,
    output stage_data_t         data,
    output stage_vld_t          vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            data <= '0;
        end else if (clr) begin
            vld <= '0;
        end else if (wr) begin
            vld[idx]  <= 1'b1;
            data[idx] <= din;
        end
    end

    // R11: a clear empties the buffer
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vld == '0));
endmodule

// File: rtl/wb_timer.sv
module wb_timer #(
    parameter int CYCLE_CLKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLE_CLKS - 1);
        end
    end

    // R8: window starts the cycle after a commit
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8: window only ends when fully counted
    p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(remain) == '0));
endmodule

// File: rtl/wb_array.sv
module wb_array
    import wb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [PAGE_W-1:0]   page,
    input  stage_data_t         data,
    input  stage_vld_t          vld,
    input  waddr_t              raddr,
    output byte_t               rdata
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int e = 0; e < ENTRIES; e++)
                if (vld[e]) mem[{page, OFF_W'(e)}] <= data[e];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wb_page_seq.sv
module wb_page_seq
    import wb_pkg::*;
#(
    parameter int CYCLE_CLKS = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_adv_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    waddr_t      addr;
    stage_data_t st_data;
    stage_vld_t  st_vld;
    logic        open_q;
    logic        stop_acc, ld_acc, wr_acc, rd_acc, commit;

    // strobe acceptance: nothing while busy, stop > load > write > read
    assign open_q   = !busy_o;
    assign stop_acc = open_q && stop_i;
    assign ld_acc   = open_q && ld_i && !stop_i;
    assign wr_acc   = open_q && wr_i && !stop_i && !ld_i;
    assign rd_acc   = open_q && rd_adv_i && !stop_i && !ld_i && !wr_i;
    assign commit   = stop_acc && (st_vld != '0);

    wb_addr_ctr u_ctr (
        .clk(clk), .rst(rst),
        .ld(ld_acc), .ld_val(waddr_t'(ld_addr_i)),
        .wr(wr_acc), .rd(rd_acc),
        .addr(addr)
    );

    wb_stage u_stage (
        .clk(clk), .rst(rst),
        .clr(stop_acc || ld_acc),
        .wr(wr_acc), .idx(addr.off), .din(wr_data_i),
        .data(st_data), .vld(st_vld)
    );

    wb_array u_array (
        .clk(clk), .rst(rst),
        .commit(commit), .page(addr.page),
        .data(st_data), .vld(st_vld),
        .raddr(addr), .rdata(rd_data_o)
    );

    wb_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk(clk), .rst(rst),
        .start(commit), .busy(busy_o)
    );

    assign addr_o = addr;

    // R9: counter frozen while busy
    p_frozen_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(addr_o));

    // R10: empty stop never starts a window
    p_empty_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !busy_o && (st_vld == '0)) |=> !busy_o);

    // R12: stop outranks load
    p_stop_first_r12: assert property (@(posedge clk) disable iff (rst)
        (stop_i && ld_i && !busy_o) |=> $stable(addr_o));
endmodule

// File: tb/wb_page_seq_test.sv
module wb_page_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CYC = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       ld_i, wr_i, rd_adv_i, stop_i;
    logic [8:0] ld_addr_i;
    logic [7:0] wr_data_i;
    logic       busy_o;
    logic [8:0] addr_o;
    logic [7:0] rd_data_o;

    int checks = 0;
    int errors = 0;

    logic [7:0]  ref_mem [512];
    logic [7:0]  ref_stage [16];
    logic [15:0] ref_vld;
    logic [8:0]  ref_cnt;

    wb_page_seq #(.CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst(rst),
        .ld_i(ld_i), .ld_addr_i(ld_addr_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i),
        .rd_adv_i(rd_adv_i), .stop_i(stop_i),
        .busy_o(busy_o), .addr_o(addr_o), .rd_data_o(rd_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] wr_step(input logic [8:0] a);
        return {a[8:4], a[3:0] + 4'd1};
    endfunction

    task automatic do_load(input logic [8:0] a);
        ld_i = 1'b1; ld_addr_i = a;
        @(negedge clk);
        ld_i = 1'b0;
        ref_cnt = a; ref_vld = '0;
        check(addr_o == a, "R2 load", addr_o, a);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_i = 1'b0;
        ref_stage[ref_cnt[3:0]] = d;
        ref_vld[ref_cnt[3:0]] = 1'b1;
        ref_cnt = wr_step(ref_cnt);
    endtask

    task automatic do_read(input string req);
        check(rd_data_o == ref_mem[ref_cnt], req, rd_data_o, ref_mem[ref_cnt]);
        rd_adv_i = 1'b1;
        @(negedge clk);
        rd_adv_i = 1'b0;
        ref_cnt = ref_cnt + 9'd1;
    endtask

    task automatic do_stop();
        int n;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        if (ref_vld != '0) begin
            for (int e = 0; e < 16; e++)
                if (ref_vld[e]) ref_mem[{ref_cnt[8:4], e[3:0]}] = ref_stage[e];
            ref_vld = '0;
            n = 0;
            while (busy_o && n < CYC + 10) begin
                n++;
                @(negedge clk);
            end
            check(n == CYC, "R8 busy length", n, CYC);
        end else begin
            check(busy_o == 1'b0, "R10 empty stop no busy", busy_o, 0);
        end
        check(addr_o == ref_cnt, "R6 counter after stop", addr_o, ref_cnt);
    endtask

    task automatic check_page(input logic [8:0] base, input string req);
        do_load({base[8:4], 4'd0});
        for (int i = 0; i < 16; i++) do_read(req);
    endtask

    initial begin
        logic [8:0] a;
        int nb;
        void'($urandom(32'd20240611));
        rst = 1'b1; ld_i = 0; wr_i = 0; rd_adv_i = 0; stop_i = 0;
        ld_addr_i = '0; wr_data_i = '0;
        for (int i = 0; i < 512; i++) ref_mem[i] = '0;
        for (int i = 0; i < 16; i++) ref_stage[i] = '0;
        ref_vld = '0; ref_cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        check(addr_o == 9'd0, "R1 addr after reset", addr_o, 0);
        check(rd_data_o == 8'd0, "R1 array zero", rd_data_o, 0);

        // R3 single byte, counter step inside page
        do_load(9'h123);
        do_write(8'hA5);
        check(addr_o == 9'h124, "R3 write step", addr_o, 9'h124);
        do_stop();
        do_load(9'h123);
        do_read("R7 byte committed");
        check(addr_o == 9'h124, "R6 read counter n+1", addr_o, 9'h124);

        // R7 array untouched before stop; R3 wrap of a full page
        do_load(9'h040);
        for (int i = 0; i < 16; i++) do_write(8'h10 + 8'(i));
        check(addr_o == 9'h040, "R3 page wrap counter", addr_o, 9'h040);
        check(rd_data_o == 8'h00, "R7 no write before stop", rd_data_o, 0);
        do_stop();
        check_page(9'h040, "R7 page commit");

        // R4 more than sixteen bytes overwrite within the page
        do_load(9'h0FE);
        for (int i = 0; i < 19; i++) do_write(8'hC0 + 8'(i));
        check(addr_o == 9'h0F1, "R4 wrapped counter", addr_o, 9'h0F1);
        do_stop();
        check_page(9'h0F0, "R4 overwrite in page");

        // R11 partial page, and load discards staging
        do_load(9'h085);
        do_write(8'h77);
        do_load(9'h088);
        do_write(8'h31);
        do_write(8'h32);
        do_stop();
        check_page(9'h080, "R11 only staged entries");

        // R10 empty stop after word address
        do_load(9'h1A7);
        do_stop();
        check(addr_o == 9'h1A7, "R10 counter kept", addr_o, 9'h1A7);

        // R5 sequential read rolls 511 to 0
        do_load(9'h1FE);
        do_read("R5 read 510");
        do_read("R5 read 511");
        check(addr_o == 9'h000, "R5 rollover", addr_o, 0);
        do_read("R5 read 0");

        // R9 strobes during busy ignored
        do_load(9'h150);
        do_write(8'h5A);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        ref_mem[9'h150] = 8'h5A; ref_vld = '0;
        ld_i = 1'b1; ld_addr_i = 9'h003; @(negedge clk); ld_i = 1'b0;
        wr_i = 1'b1; wr_data_i = 8'hEE; @(negedge clk); wr_i = 1'b0;
        rd_adv_i = 1'b1; @(negedge clk); rd_adv_i = 1'b0;
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        check(busy_o == 1'b1, "R9 still busy", busy_o, 1);
        while (busy_o) @(negedge clk);
        check(addr_o == 9'h151, "R9 counter untouched", addr_o, 9'h151);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        check(busy_o == 1'b0, "R9 nothing staged in busy", busy_o, 0);
        check_page(9'h150, "R9 array untouched");
        check_page(9'h000, "R9 load target untouched");

        // R12 stop wins over load and write
        do_load(9'h060);
        do_write(8'h9C);
        stop_i = 1'b1; ld_i = 1'b1; ld_addr_i = 9'h011; wr_i = 1'b1; wr_data_i = 8'h44;
        @(negedge clk);
        stop_i = 1'b0; ld_i = 1'b0; wr_i = 1'b0;
        ref_mem[9'h060] = 8'h9C; ref_vld = '0;
        check(addr_o == 9'h061, "R12 stop priority", addr_o, 9'h061);
        while (busy_o) @(negedge clk);
        check_page(9'h060, "R12 commit only stop");

        // random bursts
        for (int r = 0; r < 12; r++) begin
            a  = 9'($urandom_range(0, 511));
            nb = $urandom_range(0, 20);
            do_load(a);
            for (int i = 0; i < nb; i++) do_write(8'($urandom));
            do_stop();
            check_page(a, "R7 random page");
            for (int i = 0; i < 3; i++) do_read("R6 random sequential");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule